// File: doc/BRIEF.md
# CAN Mailbox Acceptance Filter and Transmit Arbiter

This block keeps sixteen message mailboxes for a CAN controller. It sits between a frame engine, which decodes and sends frames on the bus, and a host register port. The host gives each mailbox a role: unused, receive or transmit. A receive mailbox holds an identifier and its format. A transmit mailbox holds a complete frame that waits to go out.

When the frame engine presents a decoded frame, each receive mailbox compares the frame's identifier with its own, under an acceptance mask. The frame is stored in one matching mailbox, together with the value of a 16-bit free-running timer. Mailbox 0 acts as the time-synchronization mailbox: when a frame is accepted into it, the timer restarts from zero. Among the transmit mailboxes that are waiting, the block continuously offers one to the frame engine. The choice is either the one with the highest bus priority or the one with the lowest index. When the engine reports that the frame went out, that mailbox is stamped and flagged.

Each mailbox has an event flag. The flag reaches the interrupt output only through a per-mailbox enable. Clearing the flag also frees a receive mailbox.

Top module: `can_mb_hub`

## Requirements
- R1: While reset is held, `tx_req`, `irq`, `ovr`, `full` and `ts_now` are all zero.
- R2: Identifiers are 29 bits wide. A standard (IDE=0) identifier sits in bits 28:18, and for a standard frame bits 17:0 are never compared. A receive mailbox matches a frame only when its IDE equals the frame's IDE and every identifier bit whose mask bit is 1 is equal. A mask bit of 0 means the bit is not compared.
- R3: Mailboxes 0 to 13 use the shared mask (`mask_sel`=0). Mailbox 14 uses its own mask (`mask_sel`=1), and mailbox 15 uses its own mask (`mask_sel`=2).
- R4: A frame goes to the lowest-index matching mailbox whose `full` bit is clear. If every matching mailbox is full, the frame overwrites the highest-index matching mailbox and sets that mailbox's `ovr` bit. A frame that matches nothing changes nothing.
- R5: `ts_now` rises by one each clock. A stored frame records the `ts_now` value of the cycle in which it is accepted. Its identifier, DLC and data can be read through `rd_idx` one cycle later.
- R6: Accepting a frame into mailbox 0 makes `ts_now` read 0 in the next cycle.
- R7: With `order_by_id`=1, `tx_idx` names the waiting mailbox with the smallest key {id[28:18], IDE, id[17:0] (zero when IDE=0), RTR}. Ties go to the lower index. So a standard frame beats an extended frame with the same base, and a data frame beats a remote frame.
- R8: With `order_by_id`=0, `tx_idx` names the lowest-index waiting transmit mailbox.
- R9: While `listen_only` is 1, `tx_req` is 0 from the next cycle on, and `tx_done` has no effect.
- R10: `irq` equals the event flags ANDed with `irq_en`. A flag is set by an accepted frame or a completed transmission. A bit of `flag_clr` clears that mailbox's flag, `ovr` and `full` bits.
- R11: `tx_done` while `tx_req`=1 retires mailbox `tx_idx`: it sets that mailbox's flag, stamps it with `ts_now`, and from the next cycle the mailbox is no longer offered.
- R12: A configuration write sets the mailbox's role (0 unused, 1 receive, 2 transmit), its frame fields and its pending state. It clears the mailbox's flag, `full` and `ovr` bits. The new selection shows on `tx_req`/`tx_idx` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Mailbox being configured |
| cfg_kind | input | 2 | Role: 0 unused, 1 receive, 2 transmit |
| cfg_id | input | 29 | Identifier (standard in bits 28:18) |
| cfg_ide | input | 1 | Extended-format flag |
| cfg_rtr | input | 1 | Remote-frame flag |
| cfg_dlc | input | 4 | Data length code |
| cfg_data | input | 64 | Data bytes |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 2 | 0 shared, 1 mailbox 14, 2 mailbox 15 |
| mask_val | input | 29 | Mask value |
| order_by_id | input | 1 | 1 priority order, 0 index order |
| listen_only | input | 1 | Suppresses all transmit offers |
| irq_en | input | 16 | Per-mailbox interrupt enable |
| flag_clr | input | 16 | Per-mailbox flag clear |
| rx_valid | input | 1 | Decoded frame present |
| rx_id | input | 29 | Frame identifier |
| rx_ide | input | 1 | Frame is extended |
| rx_rtr | input | 1 | Frame is remote |
| rx_dlc | input | 4 | Frame data length |
| rx_data | input | 64 | Frame data |
| tx_done | input | 1 | Offered frame was sent |
| rd_idx | input | 4 | Mailbox to read |
| rd_id | output | 29 | Stored identifier |
| rd_ide | output | 1 | Stored IDE |
| rd_rtr | output | 1 | Stored RTR |
| rd_dlc | output | 4 | Stored DLC |
| rd_data | output | 64 | Stored data |
| rd_stamp | output | 16 | Stored timestamp |
| tx_req | output | 1 | A transmit mailbox is offered |
| tx_idx | output | 4 | Offered mailbox |
| irq | output | 16 | Masked event flags |
| ovr | output | 16 | Overwrite indication |
| full | output | 16 | Receive mailbox holds a frame |
| ts_now | output | 16 | Free-running timer |

## Verification
A wrong match or a wrong choice of target shows on `full` and `ovr` one clock after the frame, because the wrong bit flips or the right one stays put. A wrong timer value appears at once in `ts_now`, or one read later in `rd_stamp`. A damaged priority key or order mode shows on `tx_idx` the cycle after the pending set changes. A stale pending bit keeps offering a mailbox that has already gone out. Flag errors reach `irq` in the same cycle as the event.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int EXT_W = ID_W - STD_W;
  localparam int KEY_W = ID_W + 2;

  typedef enum logic [1:0] {
    MB_OFF = 2'd0,
    MB_RX  = 2'd1,
    MB_TX  = 2'd2
  } mb_kind_e;

  // Bus-priority key: smaller wins. Base bits, then format, then extension, then RTR.
  function automatic logic [KEY_W-1:0] mk_key(input logic [ID_W-1:0] id,
                                              input logic ide, input logic rtr);
    logic [EXT_W-1:0] lo;
    lo = ide ? id[EXT_W-1:0] : '0;
    return {id[ID_W-1:EXT_W], ide, lo, rtr};
  endfunction
endpackage

// File: rtl/can_mb_timer.sv
module can_mb_timer #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync,
  output logic [TS_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (sync) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_mb_match.sv
module can_mb_match import can_mb_pkg::*; #(
  parameter int NMB = 16
) (
  input  logic [ID_W-1:0] mb_id [NMB],
  input  logic [NMB-1:0]  mb_ide,
  input  logic [NMB-1:0]  is_rx,
  input  logic [ID_W-1:0] gmask,
  input  logic [ID_W-1:0] mask_a,
  input  logic [ID_W-1:0] mask_b,
  input  logic [ID_W-1:0] rx_id,
  input  logic            rx_ide,
  output logic [NMB-1:0]  hit
);
  logic [ID_W-1:0] fld;
  assign fld = rx_ide ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {EXT_W{1'b0}}};

  for (genvar g = 0; g < NMB; g++) begin : g_mb
    logic [ID_W-1:0] m;
    if (g < NMB - 2) begin : g_shared
      assign m = gmask;
    end else if (g == NMB - 2) begin : g_own_a
      assign m = mask_a;
    end else begin : g_own_b
      assign m = mask_b;
    end
    assign hit[g] = is_rx[g] && (mb_ide[g] == rx_ide) &&
                    (((mb_id[g] ^ rx_id) & m & fld) == '0);
  end
endmodule

// File: rtl/can_mb_txsel.sv
module can_mb_txsel import can_mb_pkg::*; #(
  parameter int NMB = 16,
  localparam int IW = $clog2(NMB)
) (
  input  logic [NMB-1:0]   elig,
  input  logic [KEY_W-1:0] key [NMB],
  input  logic             by_id,
  output logic             any,
  output logic [IW-1:0]    idx
);
  logic [KEY_W-1:0] best;
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < NMB; i++) begin
      if (elig[i] && (!any || (by_id && key[i] < best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = key[i];
      end
    end
  end
endmodule

// File: rtl/can_mb_hub.sv
module can_mb_hub import can_mb_pkg::*; #(
  parameter int NMB   = 16,
  parameter int NBYTE = 8,
  parameter int TS_W  = 16,
  localparam int IW   = $clog2(NMB),
  localparam int DW   = 8 * NBYTE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [1:0]      cfg_kind,
  input  logic [ID_W-1:0] cfg_id,
  input  logic            cfg_ide,
  input  logic            cfg_rtr,
  input  logic [3:0]      cfg_dlc,
  input  logic [DW-1:0]   cfg_data,
  input  logic            mask_we,
  input  logic [1:0]      mask_sel,
  input  logic [ID_W-1:0] mask_val,
  input  logic            order_by_id,
  input  logic            listen_only,
  input  logic [NMB-1:0]  irq_en,
  input  logic [NMB-1:0]  flag_clr,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  input  logic            rx_ide,
  input  logic            rx_rtr,
  input  logic [3:0]      rx_dlc,
  input  logic [DW-1:0]   rx_data,
  input  logic            tx_done,
  input  logic [IW-1:0]   rd_idx,
  output logic [ID_W-1:0] rd_id,
  output logic            rd_ide,
  output logic            rd_rtr,
  output logic [3:0]      rd_dlc,
  output logic [DW-1:0]   rd_data,
  output logic [TS_W-1:0] rd_stamp,
  output logic            tx_req,
  output logic [IW-1:0]   tx_idx,
  output logic [NMB-1:0]  irq,
  output logic [NMB-1:0]  ovr,
  output logic [NMB-1:0]  full,
  output logic [TS_W-1:0] ts_now
);
  // Mailbox contents
  mb_kind_e        kind   [NMB];
  logic [ID_W-1:0] mid    [NMB];
  logic [NMB-1:0]  mide, mrtr;
  logic [3:0]      mdlc   [NMB];
  logic [DW-1:0]   mdat   [NMB];
  logic [TS_W-1:0] mstamp [NMB];

  logic [NMB-1:0]  pend_q, flag_q;
  logic [NMB-1:0]  full_n, ovr_n, pend_n, flag_n;
  logic [ID_W-1:0] gmask, mask_a, mask_b;
  logic [NMB-1:0]  is_rx, hit;
  logic [IW-1:0]   tgt;
  logic            acc, tx_fire, ts_sync;
  logic [KEY_W-1:0] key [NMB];
  logic            sel_any;
  logic [IW-1:0]   sel_idx;

  always_comb
    for (int i = 0; i < NMB; i++) is_rx[i] = (kind[i] == MB_RX);

  can_mb_match #(.NMB(NMB)) u_match (
    .mb_id(mid), .mb_ide(mide), .is_rx(is_rx), .gmask(gmask),
    .mask_a(mask_a), .mask_b(mask_b), .rx_id(rx_id), .rx_ide(rx_ide), .hit(hit)
  );

  // Target: lowest empty hit, else the highest hit (overwritten)
  always_comb begin
    logic found;
    found = 1'b0;
    tgt   = '0;
    for (int i = 0; i < NMB; i++)
      if (hit[i] && !full[i] && !found) begin
        tgt   = IW'(i);
        found = 1'b1;
      end
    if (!found)
      for (int i = 0; i < NMB; i++)
        if (hit[i]) tgt = IW'(i);
  end

  assign acc     = rx_valid && (|hit);
  assign tx_fire = tx_done && tx_req;
  assign ts_sync = acc && (tgt == '0);

  can_mb_timer #(.TS_W(TS_W)) u_timer (
    .clk(clk), .rst(rst), .sync(ts_sync), .cnt(ts_now)
  );

  // Status next state: clears first, events next, host write last
  always_comb begin
    full_n = full   & ~flag_clr;
    ovr_n  = ovr    & ~flag_clr;
    flag_n = flag_q & ~flag_clr;
    pend_n = pend_q;
    if (acc) begin
      ovr_n[tgt]  = ovr_n[tgt] | full_n[tgt];
      full_n[tgt] = 1'b1;
      flag_n[tgt] = 1'b1;
    end
    if (tx_fire) begin
      pend_n[tx_idx] = 1'b0;
      flag_n[tx_idx] = 1'b1;
    end
    if (cfg_we) begin
      full_n[cfg_idx] = 1'b0;
      ovr_n[cfg_idx]  = 1'b0;
      flag_n[cfg_idx] = 1'b0;
      pend_n[cfg_idx] = (cfg_kind == MB_TX);
    end
  end

  // Keys follow the contents that will hold after this edge
  always_comb
    for (int i = 0; i < NMB; i++)
      key[i] = (cfg_we && cfg_idx == IW'(i)) ? mk_key(cfg_id, cfg_ide, cfg_rtr)
                                              : mk_key(mid[i], mide[i], mrtr[i]);

  can_mb_txsel #(.NMB(NMB)) u_txsel (
    .elig(pend_n), .key(key), .by_id(order_by_id), .any(sel_any), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= '0;
      ovr    <= '0;
      pend_q <= '0;
      flag_q <= '0;
      irq    <= '0;
      tx_req <= 1'b0;
      tx_idx <= '0;
      gmask  <= '1;
      mask_a <= '1;
      mask_b <= '1;
      for (int i = 0; i < NMB; i++) kind[i] <= MB_OFF;
    end else begin
      full   <= full_n;
      ovr    <= ovr_n;
      pend_q <= pend_n;
      flag_q <= flag_n;
      irq    <= flag_n & irq_en;
      tx_req <= sel_any && !listen_only;
      tx_idx <= sel_idx;
      if (mask_we) begin
        case (mask_sel)
          2'd0:    gmask  <= mask_val;
          2'd1:    mask_a <= mask_val;
          2'd2:    mask_b <= mask_val;
          default: ;
        endcase
      end
      if (cfg_we) kind[cfg_idx] <= mb_kind_e'(cfg_kind);
    end
  end

  // Frame store and read port (no reset)
  always_ff @(posedge clk) begin
    if (acc) begin
      mid[tgt]    <= rx_id;
      mide[tgt]   <= rx_ide;
      mrtr[tgt]   <= rx_rtr;
      mdlc[tgt]   <= rx_dlc;
      mdat[tgt]   <= rx_data;
      mstamp[tgt] <= ts_now;
    end
    if (tx_fire) mstamp[tx_idx] <= ts_now;
    if (cfg_we) begin
      mid[cfg_idx]  <= cfg_id;
      mide[cfg_idx] <= cfg_ide;
      mrtr[cfg_idx] <= cfg_rtr;
      mdlc[cfg_idx] <= cfg_dlc;
      mdat[cfg_idx] <= cfg_data;
    end
    rd_id    <= mid[rd_idx];
    rd_ide   <= mide[rd_idx];
    rd_rtr   <= mrtr[rd_idx];
    rd_dlc   <= mdlc[rd_idx];
    rd_data  <= mdat[rd_idx];
    rd_stamp <= mstamp[rd_idx];
  end
endmodule

// File: rtl/can_mb_hub_chk.sv
module can_mb_hub_chk #(
  parameter int NMB  = 16,
  parameter int TS_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            listen_only,
  input logic            tx_req,
  input logic [NMB-1:0]  irq_en,
  input logic [NMB-1:0]  irq,
  input logic [NMB-1:0]  ovr,
  input logic [NMB-1:0]  full,
  input logic [TS_W-1:0] ts_now,
  input logic            ts_sync
);
  a_r9_listen_blocks: assert property (@(posedge clk) disable iff (rst)
    listen_only |=> !tx_req);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> ((irq & ~$past(irq_en)) == '0));

  a_r4_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
    (|ovr) |-> ((ovr & ~full) == '0));

  a_r6_sync_zero: assert property (@(posedge clk) disable iff (rst)
    ts_sync |=> (ts_now == '0));

  a_r5_timer_tick: assert property (@(posedge clk) disable iff (rst)
    !ts_sync |=> (ts_now == TS_W'($past(ts_now) + 1'b1)));
endmodule

bind can_mb_hub can_mb_hub_chk #(.NMB(NMB), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .listen_only(listen_only), .tx_req(tx_req),
  .irq_en(irq_en), .irq(irq), .ovr(ovr), .full(full),
  .ts_now(ts_now), .ts_sync(ts_sync)
);

// File: tb/sim_can_mb_hub.sv
module sim_can_mb_hub;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [1:0]  cfg_kind;
  logic [28:0] cfg_id;
  logic        cfg_ide, cfg_rtr;
  logic [3:0]  cfg_dlc;
  logic [63:0] cfg_data;
  logic        mask_we;
  logic [1:0]  mask_sel;
  logic [28:0] mask_val;
  logic        order_by_id, listen_only;
  logic [15:0] irq_en, flag_clr;
  logic        rx_valid;
  logic [28:0] rx_id;
  logic        rx_ide, rx_rtr;
  logic [3:0]  rx_dlc;
  logic [63:0] rx_data;
  logic        tx_done;
  logic [3:0]  rd_idx;
  logic [28:0] rd_id;
  logic        rd_ide, rd_rtr;
  logic [3:0]  rd_dlc;
  logic [63:0] rd_data;
  logic [15:0] rd_stamp;
  logic        tx_req;
  logic [3:0]  tx_idx;
  logic [15:0] irq, ovr, full, ts_now;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_mb_hub u0 (.*);

  // vector: {clear, ide, id, expected full, expected ovr}
  localparam int NV = 11;
  localparam logic [77:0] VEC [NV] = '{
    {16'h0000, 1'b0, {11'h123, 18'h00000}, 16'h0002, 16'h0000},
    {16'h0000, 1'b0, {11'h123, 18'h00000}, 16'h0006, 16'h0000},
    {16'h0000, 1'b0, {11'h123, 18'h00000}, 16'h0006, 16'h0004},
    {16'h0000, 1'b1, {11'h123, 18'h00055}, 16'h000E, 16'h0004},
    {16'h0000, 1'b1, {11'h123, 18'h00056}, 16'h400E, 16'h0004},
    {16'h0000, 1'b0, {11'h124, 18'h00000}, 16'h400E, 16'h0004},
    {16'h0000, 1'b0, {11'h555, 18'h00000}, 16'hC00E, 16'h0004},
    {16'h0000, 1'b1, {11'h555, 18'h00000}, 16'hC00E, 16'h4004},
    {16'hFFFF, 1'b0, {11'h123, 18'h00001}, 16'h0002, 16'h0000},
    {16'h0000, 1'b1, {11'h3AA, 18'h00007}, 16'h4002, 16'h0000},
    {16'h0000, 1'b0, {11'h100, 18'h00000}, 16'h4003, 16'h0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [1:0] k, input logic [28:0] id,
                     input logic ide, input logic rtr);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_kind = k; cfg_id = id;
    cfg_ide = ide; cfg_rtr = rtr; cfg_dlc = 4'd2; cfg_data = 64'(idx);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(input logic [1:0] sel, input logic [28:0] v);
    mask_we = 1'b1; mask_sel = sel; mask_val = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic send_rx(input logic ide, input logic [28:0] id, input logic [3:0] dlc,
                         input logic [63:0] d);
    rx_valid = 1'b1; rx_ide = ide; rx_id = id; rx_rtr = 1'b0; rx_dlc = dlc; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin
    logic [15:0] t;
    rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_kind = 0; cfg_id = 0; cfg_ide = 0;
    cfg_rtr = 0; cfg_dlc = 0; cfg_data = 0; mask_we = 0; mask_sel = 0; mask_val = 0;
    order_by_id = 1'b1; listen_only = 1'b0; irq_en = 16'h0000; flag_clr = 16'h0000;
    rx_valid = 0; rx_id = 0; rx_ide = 0; rx_rtr = 0; rx_dlc = 0; rx_data = 0;
    tx_done = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_req", 64'(tx_req), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 full", 64'(full), 64'd0);
    chk("R1 ovr", 64'(ovr), 64'd0);
    chk("R1 ts_now", 64'(ts_now), 64'd0);
    rst = 1'b0;

    // R2/R3 masks and receive mailboxes
    set_mask(2'd0, {11'h7FF, 18'h00000});
    set_mask(2'd1, 29'h0);
    set_mask(2'd2, 29'h1FFFFFFF);
    cfg(0, 2'd1, {11'h100, 18'h0}, 1'b0, 1'b0);
    cfg(1, 2'd1, {11'h123, 18'h0}, 1'b0, 1'b0);
    cfg(2, 2'd1, {11'h123, 18'h0}, 1'b0, 1'b0);
    cfg(3, 2'd1, {11'h123, 18'h00055}, 1'b1, 1'b0);
    cfg(14, 2'd1, 29'h0, 1'b1, 1'b0);
    cfg(15, 2'd1, {11'h555, 18'h0}, 1'b0, 1'b0);

    // R2 R3 R4 vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][77:62] != 16'h0) begin
        flag_clr = VEC[v][77:62];
        @(negedge clk);
        flag_clr = 16'h0;
      end
      send_rx(VEC[v][61], VEC[v][60:32], 4'd8, 64'hA5A5_0000_0000_0000 | 64'(v));
      chk($sformatf("R2/R3/R4 vec%0d full", v), 64'(full), 64'(VEC[v][31:16]));
      chk($sformatf("R4 vec%0d ovr", v), 64'(ovr), 64'(VEC[v][15:0]));
    end
    // R6: last vector landed in mailbox 0
    chk("R6 timer cleared", 64'(ts_now), 64'd0);
    @(negedge clk);
    chk("R5 timer ticks", 64'(ts_now), 64'd1);

    // R10 clear frees mailboxes; R5 stamp and stored frame
    flag_clr = 16'hFFFF;
    @(negedge clk);
    flag_clr = 16'h0;
    chk("R10 clear full", 64'(full), 64'd0);
    t = ts_now;
    send_rx(1'b0, {11'h123, 18'h0}, 4'd5, 64'h1122_3344_5566_7788);
    rd_idx = 4'd1;
    @(negedge clk);
    chk("R5 stamp", 64'(rd_stamp), 64'(t));
    chk("R5 dlc", 64'(rd_dlc), 64'd5);
    chk("R5 data", rd_data, 64'h1122_3344_5566_7788);
    chk("R5 id", 64'(rd_id), 64'({11'h123, 18'h0}));

    // R10 interrupt enable
    irq_en = 16'h0002;
    @(negedge clk);
    chk("R10 irq enabled", 64'(irq), 64'h0002);
    irq_en = 16'h0000;
    @(negedge clk);
    chk("R10 irq masked", 64'(irq), 64'h0000);
    irq_en = 16'hFFFF; flag_clr = 16'h0002;
    @(negedge clk);
    flag_clr = 16'h0;
    chk("R10 irq after clear", 64'(irq), 64'h0000);

    // R7 R8 R11 R12 transmit
    chk("R12 idle", 64'(tx_req), 64'd0);
    cfg(4, 2'd2, {11'h200, 18'h0}, 1'b0, 1'b0);
    chk("R12 first offer", 64'({tx_req, tx_idx}), 64'({1'b1, 4'd4}));
    cfg(5, 2'd2, {11'h100, 18'h0}, 1'b0, 1'b0);
    cfg(6, 2'd2, {11'h100, 18'h0}, 1'b1, 1'b0);
    cfg(7, 2'd2, {11'h100, 18'h0}, 1'b0, 1'b1);
    chk("R7 lowest key", 64'({tx_req, tx_idx}), 64'({1'b1, 4'd5}));
    t = ts_now;
    pulse_done();
    chk("R7 rtr after std data", 64'(tx_idx), 64'd7);
    chk("R11 flag", 64'(irq), 64'h0020);
    rd_idx = 4'd5;
    @(negedge clk);
    chk("R11 tx stamp", 64'(rd_stamp), 64'(t));
    pulse_done();
    chk("R7 ext after std", 64'(tx_idx), 64'd6);
    order_by_id = 1'b0;
    @(negedge clk);
    chk("R8 index order", 64'(tx_idx), 64'd4);
    listen_only = 1'b1;
    @(negedge clk);
    chk("R9 no offer", 64'(tx_req), 64'd0);
    pulse_done();
    listen_only = 1'b0;
    @(negedge clk);
    chk("R9 done ignored", 64'({tx_req, tx_idx}), 64'({1'b1, 4'd4}));
    pulse_done();
    chk("R11 retire", 64'(tx_idx), 64'd6);
    pulse_done();
    chk("R11 none left", 64'(tx_req), 64'd0);
    chk("R11 all flags", 64'(irq), 64'h00F0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule